// File: doc/BRIEF.md
# Byte-Wide Arithmetic and Logic Unit with Status Flags

This block is the arithmetic heart of a small accumulator-style processor. Each cycle it combines a register operand and a memory operand under a 4-bit operation code. It produces an 8-bit result and the next values of four status flags: carry, zero, negative and overflow. All paths that form the result are combinational. The four flags are held in registers that load the next values only when a flag-write enable is high.

Subtraction and compare reuse the adder. They feed it the bitwise complement of the memory operand, so a set carry means no borrow occurred. A flag that an operation does not define passes its held value through to the next-flag output. This lets the surrounding control load all four flag bits together on every flag-writing instruction. A separate output tells the caller whether the result should be written back. Compare and bit test leave the register untouched.

Top module: `alu8_core`

## Requirements
- R1: Op code 0 (add) gives result = (opa + opb + carry_i) mod 256 and sets next carry when the 9-bit sum exceeds 255.
- R2: Op code 1 (subtract) adds opa, the complement of opb and carry_i, so the result is opa − opb − (1 − carry_i) mod 256 and next carry is 1 exactly when no borrow occurred.
- R3: For add and subtract, next overflow is 1 exactly when the signed two's-complement outcome lies outside −128..127.
- R4: Op codes 2, 3, 4 and 13 (AND, OR, XOR, pass opb) set next negative from result bit 7 and next zero when the result is 0, and leave carry and overflow at their held values.
- R5: Op code 5 (compare) sets negative and zero from (opa − opb) mod 256 and carry when opa ≥ opb unsigned. Its result output equals opa and its write-back flag is 0.
- R6: Op code 6 (bit test) sets zero when (opa AND opb) is 0, copies opb bit 7 to negative and opb bit 6 to overflow, keeps carry, outputs opa and has write-back 0.
- R7: Op codes 7 and 8 (increment, decrement opa) wrap modulo 256, update negative and zero, and leave carry and overflow at their held values.
- R8: Op codes 9 and 10 (shift opa left, shift right) move the bit shifted out (bit 7 or bit 0) into carry and fill the vacated bit with 0. Negative and zero follow the result, and overflow is held.
- R9: Op codes 11 and 12 (rotate opa left, rotate right) insert carry_i at bit 0 (left) or bit 7 (right), and the bit shifted out becomes next carry.
- R10: The flag registers reset to 0. They load the next-flag outputs at a clock edge when flag_we_i is 1 and hold otherwise.
- R11: Op codes 14 and 15 are reserved: the result equals opa, write-back is 0 and every next flag equals its held value.
- R12: The write-back flag is 1 for op codes 0 to 4 and 7 to 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code |
| opa_i | input | 8 | Register / accumulator operand |
| opb_i | input | 8 | Memory operand |
| carry_i | input | 1 | Carry fed into add, subtract and rotate |
| flag_we_i | input | 1 | Load enable for the flag registers |
| result_o | output | 8 | Operation result |
| result_we_o | output | 1 | Result is to be written back |
| nxt_c_o | output | 1 | Next carry |
| nxt_z_o | output | 1 | Next zero |
| nxt_n_o | output | 1 | Next negative |
| nxt_v_o | output | 1 | Next overflow |
| flag_c_o | output | 1 | Held carry |
| flag_z_o | output | 1 | Held zero |
| flag_n_o | output | 1 | Held negative |
| flag_v_o | output | 1 | Held overflow |

## Verification
The bench targets the signed boundary crossings of add and subtract: 0x7F+1, 0x80−1, and subtract with carry clear. A design that computed overflow from the raw rather than complemented operand would flag the wrong cases. Compare of equal operands must give zero and carry both set, and an inverted carry sense would clear it. Rotates with carry_i set and increment/decrement across 0xFF/0x00 catch a lost carry-in or a disturbed carry flag. Random sequences with flag_we_i toggled catch flags that load without enable or that drop held values for undefined bits.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_CMP  = 4'd5,
    OP_BIT  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_SHL  = 4'd9,
    OP_SHR  = 4'd10,
    OP_ROL  = 4'd11,
    OP_ROR  = 4'd12,
    OP_PASS = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  // flag vector bit positions
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int NUM_FLAGS = 4;

  // signed overflow of a two-input add: operands agree in sign, result differs
  function automatic logic add_ovf(input logic a_msb, input logic b_msb, input logic r_msb);
    return (~(a_msb ^ b_msb)) & (a_msb ^ r_msb);
  endfunction

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         invert,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  import alu8_pkg::*;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  assign b_eff = invert ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign sum   = wide[W-1:0];
  assign cout  = wide[W];
  assign ovf   = add_ovf(a[W-1], b_eff[W-1], wide[W-1]);
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  input  logic         right,
  input  logic         rotate,
  output logic [W-1:0] res,
  output logic         cout
);
  logic fill;
  assign fill = rotate ? cin : 1'b0;

  always_comb begin
    if (right) begin
      res  = {fill, a[W-1:1]};
      cout = a[0];
    end else begin
      res  = {a[W-2:0], fill};
      cout = a[W-1];
    end
  end
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [NF-1:0] d,
  output logic [NF-1:0] q
);
  for (genvar i = 0; i < NF; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[i] <= 1'b0;
      else if (we) q[i] <= d[i];
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         carry_i,
  input  logic         flag_we_i,
  output logic [W-1:0] result_o,
  output logic         result_we_o,
  output logic         nxt_c_o,
  output logic         nxt_z_o,
  output logic         nxt_n_o,
  output logic         nxt_v_o,
  output logic         flag_c_o,
  output logic         flag_z_o,
  output logic         flag_n_o,
  output logic         flag_v_o
);
  import alu8_pkg::*;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // adder path (add, subtract, compare)
  logic         add_inv, add_cin, add_cout, add_ovf_w;
  logic [W-1:0] add_sum;
  assign add_inv = (op == OP_SUB) || (op == OP_CMP);
  assign add_cin = (op == OP_CMP) ? 1'b1 : carry_i;

  alu8_adder #(.W(W)) u_add (
    .a(opa_i), .b(opb_i), .invert(add_inv), .cin(add_cin),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf_w)
  );

  // shifter path
  logic         sh_right, sh_rot, sh_cout;
  logic [W-1:0] sh_res;
  assign sh_right = (op == OP_SHR) || (op == OP_ROR);
  assign sh_rot   = (op == OP_ROL) || (op == OP_ROR);

  alu8_shifter #(.W(W)) u_sh (
    .a(opa_i), .cin(carry_i), .right(sh_right), .rotate(sh_rot),
    .res(sh_res), .cout(sh_cout)
  );

  // held flags
  logic [NUM_FLAGS-1:0] held, upd_mask, upd_val, nxt;

  alu8_flag_reg #(.NF(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .we(flag_we_i), .d(nxt), .q(held)
  );

  // result selection and flag definition
  logic [W-1:0] res;
  logic [W-1:0] nz_src;
  logic         wb;

  always_comb begin
    res      = opa_i;
    wb       = 1'b1;
    upd_mask = '0;
    upd_val  = '0;
    nz_src   = opa_i;
    unique case (op)
      OP_ADD, OP_SUB: begin
        res = add_sum; nz_src = add_sum;
        upd_mask = 4'b1111;
        upd_val[FL_C] = add_cout;
        upd_val[FL_V] = add_ovf_w;
      end
      OP_AND:  begin res = opa_i & opb_i; nz_src = res; upd_mask = 4'b0110; end
      OP_OR:   begin res = opa_i | opb_i; nz_src = res; upd_mask = 4'b0110; end
      OP_XOR:  begin res = opa_i ^ opb_i; nz_src = res; upd_mask = 4'b0110; end
      OP_PASS: begin res = opb_i;         nz_src = res; upd_mask = 4'b0110; end
      OP_INC:  begin res = opa_i + 1'b1;  nz_src = res; upd_mask = 4'b0110; end
      OP_DEC:  begin res = opa_i - 1'b1;  nz_src = res; upd_mask = 4'b0110; end
      OP_CMP: begin
        wb = 1'b0; nz_src = add_sum;
        upd_mask = 4'b0111;
        upd_val[FL_C] = add_cout;
      end
      OP_BIT: begin
        wb = 1'b0;
        upd_mask = 4'b1110;
        nz_src = opa_i & opb_i;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        res = sh_res; nz_src = sh_res;
        upd_mask = 4'b0111;
        upd_val[FL_C] = sh_cout;
      end
      default: wb = 1'b0;
    endcase
    upd_val[FL_Z] = (nz_src == '0);
    if (op == OP_BIT) begin
      upd_val[FL_N] = opb_i[W-1];
      upd_val[FL_V] = opb_i[W-2];
    end else begin
      upd_val[FL_N] = nz_src[W-1];
    end
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_merge
    assign nxt[i] = upd_mask[i] ? upd_val[i] : held[i];
  end

  assign result_o    = res;
  assign result_we_o = wb;
  assign nxt_c_o  = nxt[FL_C];
  assign nxt_z_o  = nxt[FL_Z];
  assign nxt_n_o  = nxt[FL_N];
  assign nxt_v_o  = nxt[FL_V];
  assign flag_c_o = held[FL_C];
  assign flag_z_o = held[FL_Z];
  assign flag_n_o = held[FL_N];
  assign flag_v_o = held[FL_V];
endmodule

// File: rtl/alu8_core_checker.sv
module alu8_core_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op_i,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic         carry_i,
  input logic         flag_we_i,
  input logic [W-1:0] result_o,
  input logic         result_we_o,
  input logic         nxt_c_o,
  input logic         nxt_z_o,
  input logic         nxt_n_o,
  input logic         nxt_v_o,
  input logic         flag_c_o,
  input logic         flag_z_o,
  input logic         flag_n_o,
  input logic         flag_v_o
);
  logic [3:0] nflags, hflags;
  assign nflags = {nxt_v_o, nxt_n_o, nxt_z_o, nxt_c_o};
  assign hflags = {flag_v_o, flag_n_o, flag_z_o, flag_c_o};

  assert_add_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd0) |-> ({nxt_c_o, result_o} == ({1'b0, opa_i} + {1'b0, opb_i} + {{W{1'b0}}, carry_i})));

  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we_i |=> $stable(hflags));

  assert_flag_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_i |=> (hflags == $past(nflags)));

  assert_cmp_nowb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd5) |-> (!result_we_o && result_o == opa_i && nxt_v_o == flag_v_o));

  assert_bit_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd6) |-> (nxt_n_o == opb_i[W-1] && nxt_v_o == opb_i[W-2] && nxt_c_o == flag_c_o));

  assert_incdec_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd7 || op_i == 4'd8) |-> (nxt_c_o == flag_c_o && nxt_v_o == flag_v_o));

  assert_rol_in_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd11) |-> (result_o[0] == carry_i && nxt_c_o == opa_i[W-1]));

  assert_ror_in_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd12) |-> (result_o[W-1] == carry_i && nxt_c_o == opa_i[0]));

  assert_rsv_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= 4'd14) |-> (nflags == hflags && !result_we_o && result_o == opa_i));
endmodule

bind alu8_core alu8_core_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
  .carry_i(carry_i), .flag_we_i(flag_we_i), .result_o(result_o),
  .result_we_o(result_we_o), .nxt_c_o(nxt_c_o), .nxt_z_o(nxt_z_o),
  .nxt_n_o(nxt_n_o), .nxt_v_o(nxt_v_o), .flag_c_o(flag_c_o),
  .flag_z_o(flag_z_o), .flag_n_o(flag_n_o), .flag_v_o(flag_v_o)
);

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] opa = '0, opb = '0;
  logic       cin = 1'b0, we = 1'b0;
  logic [7:0] result;
  logic       result_we, nc, nz, nn, nv, fc, fz, fn, fv;

  int n_checks = 0;
  int n_fail = 0;
  logic [3:0] model_flags = 4'b0000;   // {v,n,z,c}

  always #5 clk = ~clk;

  alu8_core u_alu8_core (
    .clk(clk), .rst_n(rst_n), .op_i(op), .opa_i(opa), .opb_i(opb),
    .carry_i(cin), .flag_we_i(we), .result_o(result), .result_we_o(result_we),
    .nxt_c_o(nc), .nxt_z_o(nz), .nxt_n_o(nn), .nxt_v_o(nv),
    .flag_c_o(fc), .flag_z_o(fz), .flag_n_o(fn), .flag_v_o(fv)
  );

  function automatic string req_of(input int o);
    case (o)
      0: return "R1"; 1: return "R2"; 2, 3, 4, 13: return "R4";
      5: return "R5"; 6: return "R6"; 7, 8: return "R7";
      9, 10: return "R8"; 11, 12: return "R9"; default: return "R11";
    endcase
  endfunction

  // reference model, written in integer arithmetic
  task automatic model(input int o, input int a, input int b, input int c,
                       input logic [3:0] held, output logic [7:0] r,
                       output logic [3:0] f, output logic wbx);
    int s, sa, sb, t;
    logic fc_, fz_, fn_, fv_;
    fv_ = held[3]; fn_ = held[2]; fz_ = held[1]; fc_ = held[0];
    r = a[7:0]; wbx = 1'b1; t = a;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    case (o)
      0: begin s = a + b + c; t = s % 256; fc_ = s > 255;
               s = sa + sb + c; fv_ = (s > 127) || (s < -128); end
      1: begin s = a + (255 - b) + c; t = s % 256; fc_ = s > 255;
               s = sa - sb - (1 - c); fv_ = (s > 127) || (s < -128); end
      2: t = a & b;
      3: t = a | b;
      4: t = a ^ b;
      5: begin t = (a - b + 256) % 256; fc_ = a >= b; wbx = 1'b0; end
      6: begin wbx = 1'b0; end
      7: t = (a + 1) % 256;
      8: t = (a + 255) % 256;
      9: begin fc_ = a >= 128; t = (a * 2) % 256; end
      10: begin fc_ = a % 2; t = a / 2; end
      11: begin fc_ = a >= 128; t = (a * 2) % 256 + c; end
      12: begin fc_ = a % 2; t = a / 2 + c * 128; end
      13: t = b;
      default: wbx = 1'b0;
    endcase
    if (o == 6) begin
      fz_ = (a & b) == 0; fn_ = b[7]; fv_ = b[6];
    end else if (o < 14) begin
      fz_ = (t == 0); fn_ = t >= 128;
    end
    if (wbx) r = t[7:0];
    f = {fv_, fn_, fz_, fc_};
  endtask

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  // called just after a falling edge; checks registered flags, then applies one vector
  task automatic apply(input int o, input int a, input int b, input int c, input logic w);
    logic [7:0] er; logic [3:0] ef; logic ew;
    chk("R10", "held flags", {fv, fn, fz, fc}, model_flags);
    op = o[3:0]; opa = a[7:0]; opb = b[7:0]; cin = c[0]; we = w;
    #1;
    model(o, a, b, c, model_flags, er, ef, ew);
    chk(req_of(o), "result", result, er);
    chk(req_of(o), "next flags {v,n,z,c}", {nv, nn, nz, nc}, ef);
    chk("R12", "write-back", result_we, ew);
    if (w) model_flags = ef;
  endtask

  initial begin
    #(2ms);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("R10", "reset flags", {fv, fn, fz, fc}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    apply(0, 8'h7F, 8'h01, 0, 1);   // R3 positive overflow
    @(negedge clk); apply(0, 8'hFF, 8'h01, 0, 1); // R1 carry, zero
    @(negedge clk); apply(1, 8'h80, 8'h01, 1, 1); // R2/R3 negative overflow
    @(negedge clk); apply(1, 8'h00, 8'h00, 0, 1); // R2 borrow in
    @(negedge clk); apply(5, 8'h42, 8'h42, 0, 1); // R5 equal
    @(negedge clk); apply(5, 8'h01, 8'h02, 1, 1); // R5 less
    @(negedge clk); apply(6, 8'h0F, 8'hC0, 0, 1); // R6
    @(negedge clk); apply(7, 8'hFF, 8'h00, 1, 1); // R7 wrap
    @(negedge clk); apply(8, 8'h00, 8'h00, 0, 1); // R7 wrap
    @(negedge clk); apply(12, 8'h01, 8'h00, 1, 1); // R9
    @(negedge clk); apply(11, 8'h80, 8'h00, 1, 1); // R9
    @(negedge clk); apply(10, 8'h81, 8'h00, 1, 1); // R8 zero fill
    @(negedge clk); apply(14, 8'h5A, 8'hA5, 1, 1); // R11
    @(negedge clk); apply(2, 8'hF0, 8'h0F, 0, 0); // R10 no load
    // random mix
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      apply($urandom % 16, $urandom % 256, $urandom % 256, $urandom % 2, 1'($urandom % 4 != 0));
    end
    @(negedge clk);
    chk("R10", "final held flags", {fv, fn, fz, fc}, model_flags);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule